// File: doc/BRIEF.md
# Debug Control Register Bank

This block is a bank of word-wide registers that sits behind a debug port. The port issues one request per cycle on a plain address/data interface: a strobe, a write flag, an address and write data. Each request gets a response one cycle later. The response carries read data and an error flag.

Most of the bank is plain storage that a debugger can fill and read back. One slot is different: it is the processor control word. Its two low bits drive a processor stall line and a hold-in-reset line toward the rest of the chip. Releasing the hold bit issues a one-cycle system reset pulse.

Debug logic elsewhere in the core can also demand a stall, for example when a trapped exception occurs. That demand is folded into the control word, so a debugger reading the word sees the processor as stalled. The hold-in-reset flag is exported so that break detection elsewhere can be silenced while the core is held.

Top module: `dbg_devreg_bank`

## Requirements
- R1: Addresses 0 to 27 are implemented. A request to any higher address answers with the error flag set and read data 0, and changes no register or output.
- R2: The control word is at address 4. Bit 0 is the stall request and bit 1 is the hold-in-reset request.
- R3: `sys_reset_pulse` fires only for a write to address 4 whose data has bit 1 clear while the stored bit 1 was set. Setting bit 1, rewriting it as 1, or writing 0 over a clear bit does not fire it.
- R4: `cpu_in_reset` equals stored bit 1 of the control word, from the cycle after the write that set it until the cycle after the write that clears it.
- R5: In the cycle after any write to address 4, `cpu_stall` equals bit 0 of the written data, unless `evt_stall_req` was high in the same cycle, in which case `cpu_stall` is 1.
- R6: A write to a valid address other than 4 only stores the data, which reads back unchanged. Reads of any address change nothing.
- R7: While `rst_n` is low, all 28 registers, `cpu_stall`, `cpu_in_reset`, `sys_reset_pulse` and the response outputs are cleared.
- R8: A cycle with `evt_stall_req` high sets bit 0 of the control word. From the next cycle `cpu_stall` is 1 and a read of address 4 returns bit 0 set; the other bits are kept.
- R9: `sys_reset_pulse` is high for exactly the one cycle after the qualifying write.
- R10: `rsp_valid` is high exactly in the cycle after each request, read or write. With it come `rsp_rdata` (the value stored before the request, or 0 for writes and errors) and `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the debug unit |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| evt_stall_req | input | 1 | Stall demand from internal debug events |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Address out of range |
| rsp_rdata | output | DATA_W | Read data |
| cpu_stall | output | 1 | Processor stall line |
| cpu_in_reset | output | 1 | Processor held in reset; silences break detection |
| sys_reset_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench targets the edges of the hold bit. If the reset pulse were decoded from the level of the hold bit instead of its falling edge, the repeated write of 1 would produce a pulse. A pulse that stretched or repeated would show on the cycle after the release.

Address 27 is checked against address 28 and a large address. An off-by-one range check would either reject the last register or let a write to an unimplemented address alias onto a low register, and that alias shows up on a later read-back.

A stall demand that arrives in the same cycle as a write of 0 to the control word must not be lost. A design that lets the write win would drop the stall. Reads are mixed with stall demands and hold states to show that no read disturbs state.

// File: rtl/dbg_devreg_pkg.sv
package dbg_devreg_pkg;

    // Bit positions inside the control word; the stall/hold lines decode them
    localparam int CTL_STALL_BIT = 0;
    localparam int CTL_HOLD_BIT  = 1;

    // Decoded view of the current request
    typedef struct packed {
        logic valid;     // request strobe
        logic write;     // write request
        logic in_range;  // address is implemented
        logic hit_ctrl;  // address selects the control word
    } acc_dec_t;

endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
    import dbg_devreg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_REGS  = 28,
    parameter int CTRL_ADDR = 4
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    output acc_dec_t            acc,
    output logic [NUM_REGS-1:0] wr_en
);

    localparam logic [ADDR_W-1:0] LAST_OK = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);

    always_comb begin
        acc.valid    = req_valid;
        acc.write    = req_write;
        acc.in_range = req_addr < LAST_OK;
        acc.hit_ctrl = req_addr == CTRL_A;
    end

    // One write enable per implemented slot
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
        assign wr_en[i] = req_valid && req_write && (req_addr == ADDR_W'(i));
    end

    always_comb begin
        AST_WEN_ONEHOT: assert ($onehot0(wr_en)); // R6
    end

endmodule

// File: rtl/dbg_ctrl_word.sv
module dbg_ctrl_word
    import dbg_devreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_stall_req,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              cpu_stall,
    output logic              cpu_in_reset,
    output logic              sys_reset_pulse
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              pulse;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_en) begin
            st_d.word  = wdata;
            // Release edge of the hold bit
            st_d.pulse = st_q.word[CTL_HOLD_BIT] && !wdata[CTL_HOLD_BIT];
        end
        if (evt_stall_req) begin
            st_d.word[CTL_STALL_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word       = st_q.word;
    assign cpu_stall       = st_q.word[CTL_STALL_BIT];
    assign cpu_in_reset    = st_q.word[CTL_HOLD_BIT];
    assign sys_reset_pulse = st_q.pulse;

    AST_PULSE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_pulse |-> $past(wr_en) && $fell(cpu_in_reset)); // R3
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_pulse |=> !sys_reset_pulse); // R9
    AST_STALL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !evt_stall_req) |=> cpu_stall == $past(wdata[CTL_STALL_BIT])); // R5
    AST_EVT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stall_req |=> cpu_stall); // R8
    AST_HOLD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_in_reset) |-> $past(wr_en)); // R4

endmodule

// File: rtl/dbg_store_file.sv
module dbg_store_file #(
    parameter int NUM_REGS = 28,
    parameter int DATA_W   = 32,
    parameter int SKIP_IDX = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            wr_en,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);

    logic [NUM_REGS-1:0][DATA_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i == SKIP_IDX) begin
                // slot held by the control word module
                st_d[i] = '0;
            end else if (wr_en[i]) begin
                st_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q;

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_en) |=> $stable(regs)); // R6

endmodule

// File: rtl/dbg_devreg_bank.sv
module dbg_devreg_bank
    import dbg_devreg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_REGS  = 28,
    parameter int CTRL_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              evt_stall_req,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cpu_stall,
    output logic              cpu_in_reset,
    output logic              sys_reset_pulse
);

    localparam int IDX_W = $clog2(NUM_REGS);

    acc_dec_t                        acc;
    logic [NUM_REGS-1:0]             wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] store;
    logic [DATA_W-1:0]               ctrl_word;

    dbg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .acc      (acc),
        .wr_en    (wr_en)
    );

    dbg_ctrl_word #(
        .DATA_W(DATA_W)
    ) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en[CTRL_ADDR]),
        .wdata          (req_wdata),
        .evt_stall_req  (evt_stall_req),
        .ctrl_word      (ctrl_word),
        .cpu_stall      (cpu_stall),
        .cpu_in_reset   (cpu_in_reset),
        .sys_reset_pulse(sys_reset_pulse)
    );

    dbg_store_file #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W),
        .SKIP_IDX(CTRL_ADDR)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .wdata(req_wdata),
        .regs (store)
    );

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_state_t;

    rsp_state_t rsp_d, rsp_q;
    logic [DATA_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        if (acc.in_range) begin
            sel_word = acc.hit_ctrl ? ctrl_word : store[req_addr[IDX_W-1:0]];
        end
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = acc.valid;
        if (acc.valid) begin
            rsp_d.err = !acc.in_range;
            if (!acc.write && acc.in_range) begin
                rsp_d.rdata = sel_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_BAD_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc.in_range) |=> rsp_err && rsp_rdata == '0); // R1
    AST_BAD_ADDR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc.in_range) |=> !sys_reset_pulse); // R1

endmodule

// File: tb/dbg_devreg_bank_tb.sv
module dbg_devreg_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int NREG       = 28;
    localparam int CADDR      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              evt_stall_req = 1'b0;
    logic              rsp_valid, rsp_err, cpu_stall, cpu_in_reset, sys_reset_pulse;
    logic [DATA_W-1:0] rsp_rdata;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_tag  = "R7";

    dbg_devreg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NREG), .CTRL_ADDR(CADDR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .evt_stall_req(evt_stall_req),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cpu_stall(cpu_stall), .cpu_in_reset(cpu_in_reset),
        .sys_reset_pulse(sys_reset_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [DATA_W-1:0] m_mem [NREG];
    logic              m_valid, m_err, m_pulse;
    logic [DATA_W-1:0] m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_mem[k]) m_mem[k] = '0;
            m_valid = 0; m_err = 0; m_pulse = 0; m_rdata = '0;
        end else begin
            int  a;
            bit  ok;
            a  = int'(req_addr);
            ok = a < NREG;
            m_valid = req_valid;
            m_err   = req_valid && !ok;
            m_rdata = (req_valid && !req_write && ok) ? m_mem[a] : '0;
            m_pulse = req_valid && req_write && a == CADDR &&
                      m_mem[CADDR][1] && !req_wdata[1];
            if (req_valid && req_write && ok) m_mem[a] = req_wdata;
            if (evt_stall_req) m_mem[CADDR][0] = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rsp_valid == m_valid, cur_tag, "rsp_valid", 32'(rsp_valid), 32'(m_valid));
            check(rsp_err == m_err, cur_tag, "rsp_err", 32'(rsp_err), 32'(m_err));
            check(rsp_rdata == m_rdata, cur_tag, "rsp_rdata", rsp_rdata, m_rdata);
            check(cpu_stall == m_mem[CADDR][0], cur_tag, "cpu_stall",
                  32'(cpu_stall), 32'(m_mem[CADDR][0]));
            check(cpu_in_reset == m_mem[CADDR][1], cur_tag, "cpu_in_reset",
                  32'(cpu_in_reset), 32'(m_mem[CADDR][1]));
            check(sys_reset_pulse == m_pulse, cur_tag, "sys_reset_pulse",
                  32'(sys_reset_pulse), 32'(m_pulse));
        end
    end

    // One cycle of stimulus, starting and ending on a falling edge
    task automatic cyc(input bit v, input bit w, input int a,
                       input logic [DATA_W-1:0] d, input bit e);
        req_valid = v; req_write = w; req_addr = ADDR_W'(a);
        req_wdata = d; evt_stall_req = e;
        @(negedge clk);
        req_valid = 0; req_write = 0; evt_stall_req = 0;
    endtask

    task automatic rd_expect(input int a, input logic [DATA_W-1:0] exp,
                             input bit exp_err, input string tag);
        cyc(1, 0, a, '0, 0);
        check(rsp_valid === 1'b1, tag, "read strobe", 32'(rsp_valid), 32'd1);
        check(rsp_rdata === exp, tag, "read data", rsp_rdata, exp);
        check(rsp_err === exp_err, tag, "read err", 32'(rsp_err), 32'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(cpu_stall === 0 && cpu_in_reset === 0 && sys_reset_pulse === 0 &&
              rsp_valid === 0, "R7", "outputs in reset", 32'(cpu_stall), 0);
        rst_n = 1;
        @(negedge clk);

        // R6: plain storage
        cur_tag = "R6";
        for (int i = 0; i < NREG; i++)
            if (i != CADDR) cyc(1, 1, i, 32'hA500_0000 + 32'(i * 17), 0);
        for (int i = 0; i < NREG; i++)
            if (i != CADDR) rd_expect(i, 32'hA500_0000 + 32'(i * 17), 0, "R6");
        rd_expect(27, 32'hA500_0000 + 32'(27 * 17), 0, "R6");

        // R1: out of range
        cur_tag = "R1";
        cyc(1, 1, 28, 32'hDEAD_BEEF, 0);
        check(rsp_err === 1, "R1", "write err", 32'(rsp_err), 1);
        cyc(1, 1, 200, 32'h0000_0002, 0);
        check(rsp_err === 1 && cpu_in_reset === 0, "R1", "no ctrl alias",
              32'(cpu_in_reset), 0);
        rd_expect(28, '0, 1, "R1");
        rd_expect(28 - NREG, 32'hA500_0000, 0, "R1");
        rd_expect(200 % 32, 32'hA500_0000 + 32'((200 % 32) * 17), 0, "R1");

        // R2 R5: stall bit follows writes
        cur_tag = "R5";
        cyc(1, 1, CADDR, 32'h1, 0);
        check(cpu_stall === 1, "R5", "stall set", 32'(cpu_stall), 1);
        cyc(1, 1, CADDR, 32'h0, 0);
        check(cpu_stall === 0, "R2", "stall clear", 32'(cpu_stall), 0);

        // R3 R4 R9: hold bit and release pulse
        cur_tag = "R3";
        cyc(1, 1, CADDR, 32'h2, 0);
        check(cpu_in_reset === 1 && sys_reset_pulse === 0, "R4", "hold set no pulse",
              32'(sys_reset_pulse), 0);
        cyc(1, 1, CADDR, 32'h3, 0);
        check(sys_reset_pulse === 0 && cpu_stall === 1, "R3", "rewrite hold no pulse",
              32'(sys_reset_pulse), 0);
        rd_expect(CADDR, 32'h3, 0, "R6");
        check(sys_reset_pulse === 0 && cpu_in_reset === 1, "R6", "read no effect",
              32'(cpu_in_reset), 1);
        cyc(1, 1, CADDR, 32'h0, 0);
        check(sys_reset_pulse === 1 && cpu_in_reset === 0, "R9", "pulse on release",
              32'(sys_reset_pulse), 1);
        cyc(0, 0, 0, '0, 0);
        check(sys_reset_pulse === 0, "R9", "pulse one cycle", 32'(sys_reset_pulse), 0);
        cyc(1, 1, CADDR, 32'h0, 0);
        check(sys_reset_pulse === 0, "R3", "0 over 0 no pulse", 32'(sys_reset_pulse), 0);

        // R8: internal stall demand
        cur_tag = "R8";
        cyc(1, 1, CADDR, 32'hF0, 0);
        cyc(0, 0, 0, '0, 1);
        check(cpu_stall === 1, "R8", "event stall", 32'(cpu_stall), 1);
        rd_expect(CADDR, 32'hF1, 0, "R8");
        cyc(1, 1, CADDR, 32'h0, 1);
        check(cpu_stall === 1, "R5", "event beats write", 32'(cpu_stall), 1);
        cyc(1, 1, CADDR, 32'h0, 0);
        check(cpu_stall === 0, "R5", "stall cleared", 32'(cpu_stall), 0);
        cyc(1, 0, CADDR, '0, 1);
        check(rsp_rdata === 0, "R10", "read returns pre-event value", rsp_rdata, 0);

        // R10: back-to-back requests
        cur_tag = "R10";
        for (int i = 0; i < 8; i++) cyc(1, i[0], (i * 5) % 30, 32'(i), i == 3);
        cyc(0, 0, 0, '0, 0);
        check(rsp_valid === 0, "R10", "idle no response", 32'(rsp_valid), 0);

        // R7: reset in mid-run clears everything
        cur_tag = "R7";
        cyc(1, 1, CADDR, 32'h3, 0);
        rst_n = 0;
        @(negedge clk);
        check(cpu_stall === 0 && cpu_in_reset === 0, "R7", "ctrl cleared",
              32'(cpu_in_reset), 0);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < NREG; i++) rd_expect(i, '0, 0, "R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule